// File: doc/BRIEF.md
# In-Flight Micro-Op Reorder Buffer

This block keeps the micro-ops that are in flight in a circular queue, in the order the program issued them. Each slot records a destination register number, a result word and a three-bit lifecycle code. The front end claims up to three consecutive slots per cycle at the tail. It learns from `alloc_base` which index the first claimed slot received. The scheduler and execution units then move a slot through its lifecycle by index: first dispatch, then the start of execution, then result writeback.

A slot whose result has been written back becomes ready one cycle later. On each clock edge the head examines up to three of the oldest slots and retires the leading run of ready ones. The registered retire lanes then present their destination and result to the architectural register file, with lane 0 the oldest. Only this retire path reaches committed state. A younger result that completes early waits behind an older slot that is still unfinished. A flush discards every in-flight entry.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_base` is 0, `full` is 0 and every `retire_vld` lane is 0.
- R2: When `full` is low and `alloc_cnt` is n (0..3), the n slots starting at `alloc_base` are claimed in lane order, taking destinations from `alloc_dst` lane k (bits k*REG_W up). The slots are given the code scheduled (1). `alloc_base` then advances by n, wrapping modulo DEPTH.
- R3: The occupancy changes each cycle by the number of slots claimed minus the number retired, and both may happen in the same cycle.
- R4: `full` is high exactly when fewer than three slots are unoccupied. An allocation request while `full` is high is ignored, and the occupancy never exceeds DEPTH.
- R5: Lifecycle codes: 0 free, 1 scheduled, 2 dispatched, 3 executing, 4 written back, 5 ready, 6 retiring. A dispatch is accepted only for a slot in code 1 and moves it to 2. An execute is accepted only in code 2 and moves the slot to 3. A request for a slot in any other code is ignored.
- R6: A writeback is accepted only for a slot in code 3. It stores `wb_data` and moves the slot to 4, and the slot becomes 5 on the next edge. A writeback to a slot in any other code leaves its result unchanged.
- R7: On each edge the leading slots at the head in code 5 (at most three) retire, stopping at the first slot that is not ready. The next cycle `retire_vld` shows them as a low-order run of ones, with the oldest in lane 0 and each lane's destination and result.
- R8: A retired slot spends exactly one cycle in code 6 and is then free. Its retire lane drops the following cycle unless a new retirement occurs.
- R9: `flush` empties the buffer on the next edge: all slots become free, head and tail return to 0, the occupancy becomes 0 and the retire lanes clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Discard all in-flight entries |
| alloc_cnt | input | GRP_W | Number of slots requested this cycle |
| alloc_dst | input | GRP*REG_W | Destination register per allocation lane |
| alloc_base | output | IDX_W | Index given to allocation lane 0 |
| full | output | 1 | Fewer than three free slots |
| disp_vld | input | 1 | Dispatch request |
| disp_idx | input | IDX_W | Slot being dispatched |
| exec_vld | input | 1 | Execution-start request |
| exec_idx | input | IDX_W | Slot starting execution |
| wb_vld | input | 1 | Result writeback request |
| wb_idx | input | IDX_W | Slot receiving the result |
| wb_data | input | DATA_W | Result value |
| retire_vld | output | GRP | Retire lane valid, lane 0 oldest |
| retire_dst | output | GRP*REG_W | Destination register per retire lane |
| retire_data | output | GRP*DATA_W | Result per retire lane |

## Verification
Some properties are checked on every cycle. The occupancy follows claims minus retirements and never exceeds the depth, the tail advances modulo the depth by the accepted claim count, the retire lanes always form a run starting at lane 0, and a flush leaves the pointers and lanes cleared. Other behaviours can only be shown by the bench's scenarios. These are the lifecycle gating that drops out-of-order status requests, the retention of a result over an ignored writeback, in-order retirement halting at an unfinished older slot, and slot indices wrapping past the end of the array.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_SCHED  = 3'd1,
        ST_DISP   = 3'd2,
        ST_EXEC   = 3'd3,
        ST_WBACK  = 3'd4,
        ST_READY  = 3'd5,
        ST_RETIRE = 3'd6
    } ent_state_e;

    // index arithmetic on a ring of size depth; off is always below depth
    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned depth);
        int unsigned s;
        s = base + off;
        return (s >= depth) ? s - depth : s;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 40,
    parameter int GRP   = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int GRP_W = $clog2(GRP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [GRP_W-1:0] alloc_n,
    input  logic [GRP_W-1:0] ret_n,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic [CNT_W-1:0] count_q,
    output logic             full
);
    import rob_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            s_d.head  = IDX_W'(ring_add(32'(s_q.head), 32'(ret_n), DEPTH));
            s_d.tail  = IDX_W'(ring_add(32'(s_q.tail), 32'(alloc_n), DEPTH));
            s_d.count = s_q.count + CNT_W'(alloc_n) - CNT_W'(ret_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_q  = s_q.head;
    assign tail_q  = s_q.tail;
    assign count_q = s_q.count;
    assign full    = (DEPTH - int'(s_q.count)) < GRP;

endmodule

// File: rtl/rob_entry_bank.sv
module rob_entry_bank #(
    parameter int DEPTH  = 40,
    parameter int GRP    = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int GRP_W = $clog2(GRP + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic [IDX_W-1:0]                   tail_q,
    input  logic [GRP_W-1:0]                   alloc_n,
    input  logic [GRP*REG_W-1:0]               alloc_dst,
    input  logic [IDX_W-1:0]                   head_q,
    input  logic [GRP_W-1:0]                   ret_n,
    input  logic                               disp_vld,
    input  logic [IDX_W-1:0]                   disp_idx,
    input  logic                               exec_vld,
    input  logic [IDX_W-1:0]                   exec_idx,
    input  logic                               wb_vld,
    input  logic [IDX_W-1:0]                   wb_idx,
    input  logic [DATA_W-1:0]                  wb_data,
    output rob_pkg::ent_state_e [DEPTH-1:0]    st_q,
    output logic [DEPTH-1:0][REG_W-1:0]        dst_q,
    output logic [DEPTH-1:0][DATA_W-1:0]       data_q
);
    import rob_pkg::*;

    typedef struct packed {
        ent_state_e [DEPTH-1:0]        st;
        logic [DEPTH-1:0][REG_W-1:0]   dst;
        logic [DEPTH-1:0][DATA_W-1:0]  data;
    } bank_t;

    bank_t b_d, b_q;

    // slot index reached by each allocation lane and each retire lane
    logic [GRP-1:0][IDX_W-1:0] alloc_slot;
    logic [GRP-1:0][IDX_W-1:0] ret_slot;

    for (genvar k = 0; k < GRP; k++) begin : g_lane
        assign alloc_slot[k] = IDX_W'(ring_add(32'(tail_q), k, DEPTH));
        assign ret_slot[k]   = IDX_W'(ring_add(32'(head_q), k, DEPTH));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < DEPTH; i++) begin
            // autonomous progress
            if (b_q.st[i] == ST_WBACK)  b_d.st[i] = ST_READY;
            if (b_q.st[i] == ST_RETIRE) b_d.st[i] = ST_FREE;
            // status requests, each gated by the expected prior code
            if (disp_vld && int'(disp_idx) == i && b_q.st[i] == ST_SCHED)
                b_d.st[i] = ST_DISP;
            if (exec_vld && int'(exec_idx) == i && b_q.st[i] == ST_DISP)
                b_d.st[i] = ST_EXEC;
            if (wb_vld && int'(wb_idx) == i && b_q.st[i] == ST_EXEC) begin
                b_d.st[i]   = ST_WBACK;
                b_d.data[i] = wb_data;
            end
            // head retirement
            for (int k = 0; k < GRP; k++) begin
                if (k < int'(ret_n) && int'(ret_slot[k]) == i)
                    b_d.st[i] = ST_RETIRE;
            end
            // tail allocation wins over a slot leaving the retiring code
            for (int k = 0; k < GRP; k++) begin
                if (k < int'(alloc_n) && int'(alloc_slot[k]) == i) begin
                    b_d.st[i]   = ST_SCHED;
                    b_d.dst[i]  = alloc_dst[k*REG_W +: REG_W];
                    b_d.data[i] = '0;
                end
            end
            if (flush) b_d.st[i] = ST_FREE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign st_q   = b_q.st;
    assign dst_q  = b_q.dst;
    assign data_q = b_q.data;

endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
    parameter int DEPTH  = 40,
    parameter int GRP    = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int GRP_W = $clog2(GRP + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic [IDX_W-1:0]                   head_q,
    input  logic [CNT_W-1:0]                   count_q,
    input  rob_pkg::ent_state_e [DEPTH-1:0]    st_q,
    input  logic [DEPTH-1:0][REG_W-1:0]        dst_q,
    input  logic [DEPTH-1:0][DATA_W-1:0]       data_q,
    output logic [GRP_W-1:0]                   ret_n,
    output logic [GRP-1:0]                     retire_vld,
    output logic [GRP*REG_W-1:0]               retire_dst,
    output logic [GRP*DATA_W-1:0]              retire_data
);
    import rob_pkg::*;

    typedef struct packed {
        logic [GRP-1:0]        vld;
        logic [GRP*REG_W-1:0]  dst;
        logic [GRP*DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    logic [GRP-1:0][IDX_W-1:0] slot;
    logic [GRP-1:0]            lane_rdy;
    logic [GRP-1:0]            run;

    for (genvar k = 0; k < GRP; k++) begin : g_scan
        assign slot[k]     = IDX_W'(ring_add(32'(head_q), k, DEPTH));
        assign lane_rdy[k] = (k < int'(count_q)) && (st_q[slot[k]] == ST_READY);
        if (k == 0) begin : g_first
            assign run[k] = lane_rdy[k];
        end else begin : g_next
            assign run[k] = lane_rdy[k] && run[k-1];
        end
    end

    always_comb begin
        ret_n = GRP_W'($countones(run));
        o_d   = '0;
        if (!flush) begin
            o_d.vld = run;
            for (int k = 0; k < GRP; k++) begin
                if (run[k]) begin
                    o_d.dst[k*REG_W +: REG_W]    = dst_q[slot[k]];
                    o_d.data[k*DATA_W +: DATA_W] = data_q[slot[k]];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign retire_vld  = o_q.vld;
    assign retire_dst  = o_q.dst;
    assign retire_data = o_q.data;

endmodule

// File: rtl/rob_top.sv
module rob_top #(
    parameter int DEPTH  = 40,
    parameter int GRP    = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int GRP_W = $clog2(GRP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [GRP_W-1:0]      alloc_cnt,
    input  logic [GRP*REG_W-1:0]  alloc_dst,
    output logic [IDX_W-1:0]      alloc_base,
    output logic                  full,
    input  logic                  disp_vld,
    input  logic [IDX_W-1:0]      disp_idx,
    input  logic                  exec_vld,
    input  logic [IDX_W-1:0]      exec_idx,
    input  logic                  wb_vld,
    input  logic [IDX_W-1:0]      wb_idx,
    input  logic [DATA_W-1:0]     wb_data,
    output logic [GRP-1:0]        retire_vld,
    output logic [GRP*REG_W-1:0]  retire_dst,
    output logic [GRP*DATA_W-1:0] retire_data
);
    import rob_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]               head_q;
    logic [IDX_W-1:0]               tail_q;
    logic [CNT_W-1:0]               count_q;
    logic [GRP_W-1:0]               alloc_take;
    logic [GRP_W-1:0]               ret_n;
    ent_state_e [DEPTH-1:0]         st_q;
    logic [DEPTH-1:0][REG_W-1:0]    dst_q;
    logic [DEPTH-1:0][DATA_W-1:0]   data_q;

    // a request larger than a group is clamped; nothing is taken while full
    always_comb begin
        if (full || flush)               alloc_take = '0;
        else if (int'(alloc_cnt) > GRP)  alloc_take = GRP_W'(GRP);
        else                             alloc_take = alloc_cnt;
    end

    assign alloc_base = tail_q;

    rob_ptr_ctrl #(.DEPTH(DEPTH), .GRP(GRP)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .alloc_n (alloc_take),
        .ret_n   (ret_n),
        .head_q  (head_q),
        .tail_q  (tail_q),
        .count_q (count_q),
        .full    (full)
    );

    rob_entry_bank #(.DEPTH(DEPTH), .GRP(GRP), .REG_W(REG_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .tail_q    (tail_q),
        .alloc_n   (alloc_take),
        .alloc_dst (alloc_dst),
        .head_q    (head_q),
        .ret_n     (ret_n),
        .disp_vld  (disp_vld),
        .disp_idx  (disp_idx),
        .exec_vld  (exec_vld),
        .exec_idx  (exec_idx),
        .wb_vld    (wb_vld),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .st_q      (st_q),
        .dst_q     (dst_q),
        .data_q    (data_q)
    );

    rob_retire_pick #(.DEPTH(DEPTH), .GRP(GRP), .REG_W(REG_W), .DATA_W(DATA_W)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .head_q      (head_q),
        .count_q     (count_q),
        .st_q        (st_q),
        .dst_q       (dst_q),
        .data_q      (data_q),
        .ret_n       (ret_n),
        .retire_vld  (retire_vld),
        .retire_dst  (retire_dst),
        .retire_data (retire_data)
    );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 40,
    parameter int GRP   = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int GRP_W = $clog2(GRP + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [CNT_W-1:0] count_q,
    input logic [IDX_W-1:0] tail_q,
    input logic [GRP_W-1:0] alloc_take,
    input logic [GRP-1:0]   retire_vld
);
    import rob_pkg::*;

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> int'(count_q) ==
            int'($past(count_q)) + int'($past(alloc_take)) - $countones(retire_vld));

    a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> int'(tail_q) ==
            int'(ring_add(32'($past(tail_q)), 32'($past(alloc_take)), DEPTH)));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);

    a_r7_lane_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld & (retire_vld + GRP'(1))) == '0);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (tail_q == '0) && (retire_vld == '0));

endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH), .GRP(GRP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .count_q    (count_q),
    .tail_q     (tail_q),
    .alloc_take (alloc_take),
    .retire_vld (retire_vld)
);

// File: tb/sim_rob_top.sv
`timescale 1ns/1ps
module sim_rob_top;
    localparam int DEPTH  = 40;
    localparam int GRP    = 3;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;
    localparam int GRP_W  = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  flush = 1'b0;
    logic [GRP_W-1:0]      alloc_cnt = '0;
    logic [GRP*REG_W-1:0]  alloc_dst = '0;
    logic [IDX_W-1:0]      alloc_base;
    logic                  full;
    logic                  disp_vld = 1'b0;
    logic [IDX_W-1:0]      disp_idx = '0;
    logic                  exec_vld = 1'b0;
    logic [IDX_W-1:0]      exec_idx = '0;
    logic                  wb_vld = 1'b0;
    logic [IDX_W-1:0]      wb_idx = '0;
    logic [DATA_W-1:0]     wb_data = '0;
    logic [GRP-1:0]        retire_vld;
    logic [GRP*REG_W-1:0]  retire_dst;
    logic [GRP*DATA_W-1:0] retire_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .GRP(GRP), .REG_W(REG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_cnt(alloc_cnt), .alloc_dst(alloc_dst),
        .alloc_base(alloc_base), .full(full),
        .disp_vld(disp_vld), .disp_idx(disp_idx),
        .exec_vld(exec_vld), .exec_idx(exec_idx),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data),
        .retire_vld(retire_vld), .retire_dst(retire_dst), .retire_data(retire_data)
    );

    // {request count, expected base before the request, expected full}
    localparam logic [8:0] TBL [16] = '{
        {2'd3, 6'd0,  1'b0}, {2'd1, 6'd3,  1'b0}, {2'd2, 6'd4,  1'b0}, {2'd3, 6'd6,  1'b0},
        {2'd3, 6'd9,  1'b0}, {2'd3, 6'd12, 1'b0}, {2'd3, 6'd15, 1'b0}, {2'd3, 6'd18, 1'b0},
        {2'd3, 6'd21, 1'b0}, {2'd3, 6'd24, 1'b0}, {2'd3, 6'd27, 1'b0}, {2'd3, 6'd30, 1'b0},
        {2'd3, 6'd33, 1'b0}, {2'd2, 6'd36, 1'b0}, {2'd1, 6'd38, 1'b1}, {2'd0, 6'd38, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input int n);
        alloc_cnt = GRP_W'(n);
        for (int k = 0; k < GRP; k++)
            alloc_dst[k*REG_W +: REG_W] = REG_W'(int'(alloc_base) + k);
        step();
        alloc_cnt = '0;
    endtask

    task automatic do_disp(input int idx);
        disp_vld = 1'b1; disp_idx = IDX_W'(idx); step(); disp_vld = 1'b0;
    endtask

    task automatic do_exec(input int idx);
        exec_vld = 1'b1; exec_idx = IDX_W'(idx); step(); exec_vld = 1'b0;
    endtask

    task automatic do_wb(input int idx, input int d);
        wb_vld = 1'b1; wb_idx = IDX_W'(idx); wb_data = DATA_W'(d); step(); wb_vld = 1'b0;
    endtask

    task automatic finish_all();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_all();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(alloc_base == 0, "R1 base", alloc_base, 0);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(retire_vld == 0, "R1 retire", retire_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 table of allocation groups up to and past full
        for (int v = 0; v < 16; v++) begin
            chk(alloc_base == TBL[v][6:1], "R2 base", alloc_base, TBL[v][6:1]);
            chk(full == TBL[v][0], "R4 full", full, TBL[v][0]);
            do_alloc(int'(TBL[v][8:7]));
        end
        chk(alloc_base == 38, "R4 ignored alloc", alloc_base, 38);

        // R5 R6 R7: complete slots 2,1 before the head; gated requests on slot 0
        do_disp(2); do_exec(2); do_wb(2, 1002);
        do_disp(1); do_exec(1); do_wb(1, 1001);
        do_wb(0, 16'hdead);             // R6 ignored: slot 0 is scheduled
        do_exec(0);                     // R5 ignored: slot 0 not dispatched
        step(); step();
        chk(retire_vld == 0, "R7 stop at unready head", retire_vld, 0);
        do_wb(0, 16'hbeef);             // still ignored: slot 0 not executing
        chk(retire_vld == 0, "R5 exec before disp ignored", retire_vld, 0);
        do_disp(0); do_exec(0); do_wb(0, 1000);
        step();
        chk(retire_vld == 0, "R6 ready one cycle after wb", retire_vld, 0);
        step();
        chk(retire_vld == 3'b111, "R7 three lanes", retire_vld, 7);
        chk(retire_dst[0 +: 5] == 0 && retire_dst[5 +: 5] == 1 && retire_dst[10 +: 5] == 2,
            "R7 dst order", retire_dst, 15'h0820);
        chk(retire_data[0 +: 32] == 1000, "R6 data kept lane0", retire_data[0 +: 32], 1000);
        chk(retire_data[32 +: 32] == 1001, "R7 data lane1", retire_data[32 +: 32], 1001);
        chk(retire_data[64 +: 32] == 1002, "R7 data lane2", retire_data[64 +: 32], 1002);
        chk(full == 1'b0, "R3 count dropped", full, 0);

        // R2 wrap and R3 refill; R8 lanes drop after one cycle
        do_alloc(3);
        chk(retire_vld == 0, "R8 lanes drop", retire_vld, 0);
        chk(alloc_base == 1, "R2 wrap", alloc_base, 1);
        chk(full == 1'b1, "R3 full again", full, 1);

        // R7 partial run: slot 4 ready, slot 3 not
        do_disp(4); do_exec(4); do_wb(4, 1004);
        step(); step();
        chk(retire_vld == 0, "R7 younger waits", retire_vld, 0);
        do_disp(3); do_exec(3); do_wb(3, 1003);
        step(); step();
        chk(retire_vld == 3'b011, "R7 two lanes", retire_vld, 3);
        chk(retire_data[0 +: 32] == 1003 && retire_data[32 +: 32] == 1004,
            "R7 partial data", retire_data[0 +: 32], 1003);
        chk(retire_dst[0 +: 5] == 3 && retire_dst[5 +: 5] == 4, "R7 partial dst",
            retire_dst[9:0], 10'h083);
        step();
        chk(retire_vld == 0, "R8 single retire", retire_vld, 0);

        // R9 flush
        flush = 1'b1; step(); flush = 1'b0;
        chk(alloc_base == 0, "R9 tail reset", alloc_base, 0);
        chk(full == 1'b0, "R9 empty", full, 0);
        chk(retire_vld == 0, "R9 lanes", retire_vld, 0);
        do_alloc(2);
        chk(alloc_base == 2, "R9 alloc after flush", alloc_base, 2);
        do_disp(0); do_exec(0); do_wb(0, 77);
        step(); step();
        chk(retire_vld == 3'b001 && retire_data[0 +: 32] == 77, "R9 fresh retire",
            retire_data[0 +: 32], 77);

        done = 1'b1;
        finish_all();
    end
endmodule